// File: doc/BRIEF.md
# Processor Slot Hotplug Controller

This block keeps track of a fixed set of processor slots: whether each is populated, and which of them have an insertion, a removal request or a firmware-handled removal waiting for software. Software reaches it through a 12-byte register window, using accesses of 1, 2 or 4 bytes. It first points a selector at one slot. It then reads that slot's flag byte, acknowledges events or requests an eject through flag writes, and uses a command register to decide what the 32-bit data port means. The data port can return the selector, return the slot's 64-bit hardware ID, or accept status-report values.

Platform logic drives three side strobes, each tagged with a slot number: populate (with a hot-add qualifier), removal request and removal complete. The block answers with a one-cycle interrupt pulse, a one-cycle status-report pulse that carries its values, and a one-cycle eject request that names the slot.

Command 0 starts a search for the next slot with something pending. A sequential walker performs it, examining one slot per clock. While the walker runs, `scan_busy` is high and the register port holds `req_ready` low.

Top module: `cpu_slot_ctrl`

## Requirements
- R1: After reset, slot 0 reads as populated and every other slot as empty. No slot has anything pending, selector and command are 0, `req_ready` is 1, and every pulse output is 0.
- R2: A read of the flag byte (offset 4) returns bit0 = populated, bit1 = insertion pending, bit2 = removal pending and bit4 = firmware removal requested. Bits 3 and 5 to 7 read as 0.
- R3: A write to the flag byte acts only on its lowest-priority-number set bit, in this order: bit1 clears insertion pending; otherwise bit2 clears removal pending; otherwise bit3 ejects; otherwise bit4 requests firmware removal.
- R4: An eject or a firmware-removal request has no effect when the selected slot is empty or is slot 0. A successful eject clears populated and firmware-removal, and pulses `eject_pulse` for one cycle with `eject_slot` set to the slot, in the cycle after the write.
- R5: A command write (offset 5) with a value of 0 to 3 is stored: 0 = find next pending, 1 = report event, 2 = report code, 3 = slot ID. A value of 4 or more leaves the command unchanged.
- R6: Command 0 examines slots from the selector upward, wrapping from N-1 to 0. It loads the selector with the first slot that has insertion, removal or firmware removal pending. After a full lap with no hit, the selector is unchanged. `scan_busy` stays high for k+1 cycles when the hit lies k slots ahead, and for N cycles on a miss. During that time `req_ready` is 0.
- R7: A read of the data port (offset 8) returns the selector under command 0, the low ID word under command 3, and 0 otherwise. A read at offset 0 returns the high ID word under command 3, and 0 otherwise. Slot i has ID ID_BASE + i*ID_STRIDE.
- R8: A data write under command 1 stores the slot's event value. A data write under command 2 pulses `report_pulse` in the next cycle, with the slot number, the stored event value and the written code.
- R9: While the selector is N or more, every read returns 0 and every write except a selector write (offset 0) is discarded.
- R10: A populate strobe sets populated, and with hot-add also sets insertion pending. A removal-request strobe sets removal pending. Either of these events pulses `irq_pulse` in the next cycle. A removal-complete strobe clears populated.
- R11: `req_size` 0, 1 or 2 selects a 1-, 2- or 4-byte access. Write data and read data are masked to that many low bytes, in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset in the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data, low byte at the offset |
| req_ready | output | 1 | Access accepted this cycle when high |
| req_rdata | output | 32 | Read data, valid in the accept cycle |
| side_slot | input | IDXW | Slot addressed by the side strobes |
| plug_stb | input | 1 | Populate strobe |
| plug_hot | input | 1 | Populate is a hot-add |
| unplug_req_stb | input | 1 | Removal request strobe |
| unplug_done_stb | input | 1 | Removal complete strobe |
| irq_pulse | output | 1 | Event interrupt pulse |
| report_pulse | output | 1 | Status-report pulse |
| report_slot | output | IDXW | Slot of the report |
| report_event | output | 32 | Stored event value |
| report_code | output | 32 | Written status code |
| eject_pulse | output | 1 | Eject request pulse |
| eject_slot | output | IDXW | Slot to eject |
| scan_busy | output | 1 | Search walker running |

## Verification
Read data is combinational, so the bench samples it one nanosecond after driving the read, which is before the edge that accepts it. State written at an accepting edge is visible to the next access. `eject_pulse`, `report_pulse` and `irq_pulse` are registered at the edge that takes the write or strobe, so the bench checks them just after that edge and checks them again one cycle later to see them fall. For a search, the bench counts the cycles in which `scan_busy` is high, starting just after the accepting edge. It expects k+1 cycles for a hit k slots ahead and N cycles for a miss. Every access waits on `req_ready`, so results read after a search reflect the finished walk.

// File: rtl/slot_pkg.sv
package slot_pkg;

    localparam logic [3:0] OFF_SEL   = 4'h0;
    localparam logic [3:0] OFF_FLAGS = 4'h4;
    localparam logic [3:0] OFF_CMD   = 4'h5;
    localparam logic [3:0] OFF_DATA  = 4'h8;

    typedef enum logic [1:0] {
        CMD_NEXT = 2'd0,
        CMD_EVT  = 2'd1,
        CMD_CODE = 2'd2,
        CMD_ID   = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        FOP_NONE,
        FOP_CLR_INS,
        FOP_CLR_REM,
        FOP_EJECT,
        FOP_SET_FW
    } fop_e;

    typedef struct packed {
        logic fwrem;
        logic rem;
        logic ins;
        logic present;
    } slot_flags_t;

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic fop_e decode_flags(input logic [7:0] d);
        if (d[1])      return FOP_CLR_INS;
        else if (d[2]) return FOP_CLR_REM;
        else if (d[3]) return FOP_EJECT;
        else if (d[4]) return FOP_SET_FW;
        else           return FOP_NONE;
    endfunction

    function automatic logic [7:0] pack_flags(input slot_flags_t f);
        return {3'b000, f.fwrem, 1'b0, f.rem, f.ins, f.present};
    endfunction

    function automatic logic [63:0] slot_id(input logic [63:0] base,
                                            input logic [63:0] stride,
                                            input int unsigned idx);
        return base + stride * 64'(idx);
    endfunction

endpackage

// File: rtl/slot_cell.sv
module slot_cell
    import slot_pkg::*;
#(
    parameter bit BOOT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_en,
    input  fop_e        fop,
    input  logic        plug,
    input  logic        plug_hot,
    input  logic        unplug_req,
    input  logic        unplug_done,
    output slot_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '{fwrem: 1'b0, rem: 1'b0, ins: 1'b0, present: BOOT};
        end else begin
            if (op_en) begin
                case (fop)
                    FOP_CLR_INS: flags.ins <= 1'b0;
                    FOP_CLR_REM: flags.rem <= 1'b0;
                    FOP_EJECT: begin
                        flags.present <= 1'b0;
                        flags.fwrem   <= 1'b0;
                    end
                    FOP_SET_FW:  flags.fwrem <= 1'b1;
                    default: ;
                endcase
            end
            // side strobes are applied after register writes
            if (plug) begin
                flags.present <= 1'b1;
                if (plug_hot) flags.ins <= 1'b1;
            end
            if (unplug_req)  flags.rem <= 1'b1;
            if (unplug_done) flags.present <= 1'b0;
        end
    end
endmodule

// File: rtl/slot_scan.sv
module slot_scan #(
    parameter int NSLOTS = 8,
    parameter int IDXW   = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDXW-1:0]   start_idx,
    input  logic [NSLOTS-1:0] pending,
    output logic              busy,
    output logic              hit,
    output logic [IDXW-1:0]   hit_idx
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NSLOTS - 1);

    logic [IDXW-1:0] ptr;
    logic [IDXW-1:0] steps;

    assign hit     = busy && pending[ptr];
    assign hit_idx = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ptr   <= '0;
            steps <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ptr   <= start_idx;
            steps <= '0;
        end else if (busy) begin
            if (pending[ptr] || steps == LAST) begin
                busy <= 1'b0;
            end else begin
                ptr   <= (ptr == LAST) ? '0 : ptr + 1'b1;
                steps <= steps + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_slot_ctrl.sv
module cpu_slot_ctrl
    import slot_pkg::*;
#(
    parameter int          NSLOTS    = 8,
    parameter logic [63:0] ID_BASE   = 64'h0000_0A00_0000_0100,
    parameter logic [63:0] ID_STRIDE = 64'h0000_0001_0000_0001,
    parameter int          IDXW      = $clog2(NSLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [3:0]      req_addr,
    input  logic [1:0]      req_size,
    input  logic [31:0]     req_wdata,
    output logic            req_ready,
    output logic [31:0]     req_rdata,
    input  logic [IDXW-1:0] side_slot,
    input  logic            plug_stb,
    input  logic            plug_hot,
    input  logic            unplug_req_stb,
    input  logic            unplug_done_stb,
    output logic            irq_pulse,
    output logic            report_pulse,
    output logic [IDXW-1:0] report_slot,
    output logic [31:0]     report_event,
    output logic [31:0]     report_code,
    output logic            eject_pulse,
    output logic [IDXW-1:0] eject_slot,
    output logic            scan_busy
);
    logic [31:0]       sel_q;
    cmd_e              cmd_q;
    logic [31:0]       evt_q [NSLOTS];
    slot_flags_t       flags_arr [NSLOTS];
    logic [NSLOTS-1:0] pending;

    logic [IDXW-1:0] sel_idx;
    logic            sel_ok, wr, side_ok;
    logic [31:0]     mask, wd;
    fop_e            fop;
    slot_flags_t     cur;
    logic            fop_go, cmd_wr, scan_start, scan_hit;
    logic [IDXW-1:0] scan_idx;
    logic [63:0]     cur_id;
    logic [31:0]     rd;

    assign sel_idx   = sel_q[IDXW-1:0];
    assign sel_ok    = sel_q < 32'(NSLOTS);
    assign req_ready = !scan_busy;
    assign wr        = req_valid && req_ready && req_write;
    assign mask      = size_mask(req_size);
    assign wd        = req_wdata & mask;
    assign fop       = decode_flags(wd[7:0]);
    assign cur       = flags_arr[sel_idx];
    assign side_ok   = 32'(side_slot) < 32'(NSLOTS);
    assign cur_id    = slot_id(ID_BASE, ID_STRIDE, 32'(sel_idx));

    assign fop_go = wr && sel_ok && req_addr == OFF_FLAGS &&
                    (fop == FOP_CLR_INS || fop == FOP_CLR_REM ||
                     ((fop == FOP_EJECT || fop == FOP_SET_FW) &&
                      cur.present && sel_idx != '0));
    assign cmd_wr     = wr && sel_ok && req_addr == OFF_CMD && wd[7:0] < 8'd4;
    assign scan_start = cmd_wr && wd[1:0] == CMD_NEXT;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        logic hit_sel, hit_side;
        assign hit_sel  = sel_idx == IDXW'(i);
        assign hit_side = side_slot == IDXW'(i);
        slot_cell #(.BOOT(i == 0)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .op_en      (fop_go && hit_sel),
            .fop        (fop),
            .plug       (plug_stb && hit_side),
            .plug_hot   (plug_hot),
            .unplug_req (unplug_req_stb && hit_side),
            .unplug_done(unplug_done_stb && hit_side),
            .flags      (flags_arr[i])
        );
        assign pending[i] = flags_arr[i].ins | flags_arr[i].rem | flags_arr[i].fwrem;
    end

    slot_scan #(.NSLOTS(NSLOTS), .IDXW(IDXW)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .start    (scan_start),
        .start_idx(sel_idx),
        .pending  (pending),
        .busy     (scan_busy),
        .hit      (scan_hit),
        .hit_idx  (scan_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q        <= '0;
            cmd_q        <= CMD_NEXT;
            irq_pulse    <= 1'b0;
            report_pulse <= 1'b0;
            report_slot  <= '0;
            report_event <= '0;
            report_code  <= '0;
            eject_pulse  <= 1'b0;
            eject_slot   <= '0;
            for (int i = 0; i < NSLOTS; i++) evt_q[i] <= '0;
        end else begin
            irq_pulse    <= side_ok && ((plug_stb && plug_hot) || unplug_req_stb);
            report_pulse <= 1'b0;
            eject_pulse  <= 1'b0;
            if (wr && req_addr == OFF_SEL) sel_q <= wd;
            if (scan_hit) sel_q <= 32'(scan_idx);
            if (cmd_wr) cmd_q <= cmd_e'(wd[1:0]);
            if (fop_go && fop == FOP_EJECT) begin
                eject_pulse <= 1'b1;
                eject_slot  <= sel_idx;
            end
            if (wr && sel_ok && req_addr == OFF_DATA) begin
                if (cmd_q == CMD_EVT) evt_q[sel_idx] <= wd;
                if (cmd_q == CMD_CODE) begin
                    report_pulse <= 1'b1;
                    report_slot  <= sel_idx;
                    report_event <= evt_q[sel_idx];
                    report_code  <= wd;
                end
            end
        end
    end

    always_comb begin
        rd = '0;
        if (sel_ok) begin
            case (req_addr)
                OFF_SEL:   rd = (cmd_q == CMD_ID) ? cur_id[63:32] : 32'h0;
                OFF_FLAGS: rd = {24'h0, pack_flags(cur)};
                OFF_DATA: begin
                    if (cmd_q == CMD_NEXT)    rd = sel_q;
                    else if (cmd_q == CMD_ID) rd = cur_id[31:0];
                end
                default: rd = '0;
            endcase
        end
    end
    assign req_rdata = rd & mask;

endmodule

// File: rtl/slot_ctrl_chk.sv
module slot_ctrl_chk #(
    parameter int NSLOTS = 8,
    parameter int IDXW   = $clog2(NSLOTS)
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_write,
    input logic [3:0]      req_addr,
    input logic [7:0]      wbyte,
    input logic            plug_stb,
    input logic            plug_hot,
    input logic            unplug_req_stb,
    input logic            irq_pulse,
    input logic            report_pulse,
    input logic            eject_pulse,
    input logic [IDXW-1:0] eject_slot,
    input logic            scan_busy,
    input logic [1:0]      cmd_q
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst)            busy_run <= 0;
        else if (scan_busy) busy_run <= busy_run + 1;
        else                busy_run <= 0;
    end

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past((plug_stb && plug_hot) || unplug_req_stb));

    // R4
    eject_not_boot_chk: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |-> eject_slot != '0);

    // R8
    report_source_chk: assert property (@(posedge clk) disable iff (rst)
        report_pulse |-> $past(req_valid && req_ready && req_write &&
                               req_addr == 4'h8 && cmd_q == 2'd2));

    // R6
    scan_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_busy) |-> $past(req_valid && req_write &&
                                   req_addr == 4'h5 && wbyte == 8'h00));

    // R6
    scan_stall_chk: assert property (@(posedge clk) disable iff (rst)
        scan_busy |-> !req_ready);

    // R6
    scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_run <= NSLOTS);

    // R5
    cmd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && req_addr == 4'h5 && wbyte >= 8'd4)
        |=> $stable(cmd_q));
endmodule

bind cpu_slot_ctrl slot_ctrl_chk #(.NSLOTS(NSLOTS), .IDXW(IDXW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .wbyte         (req_wdata[7:0]),
    .plug_stb      (plug_stb),
    .plug_hot      (plug_hot),
    .unplug_req_stb(unplug_req_stb),
    .irq_pulse     (irq_pulse),
    .report_pulse  (report_pulse),
    .eject_pulse   (eject_pulse),
    .eject_slot    (eject_slot),
    .scan_busy     (scan_busy),
    .cmd_q         (cmd_q)
);

// File: tb/tb_cpu_slot_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_slot_ctrl;
    localparam int N    = 8;
    localparam int IDXW = 3;

    localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_PH = 3'd2,
                           OP_PC = 3'd3, OP_UR = 3'd4, OP_UD = 3'd5;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  OP_R,  4'h4, 2'd0, 32'h0,   32'h1},    // R1 slot0 populated
        '{4'd1,  OP_R,  4'h8, 2'd2, 32'h0,   32'h0},    // R1 selector 0
        '{4'd2,  OP_W,  4'h0, 2'd2, 32'h3,   32'h0},
        '{4'd2,  OP_R,  4'h4, 2'd0, 32'h0,   32'h0},    // R2 empty slot
        '{4'd10, OP_PH, 4'h0, 2'd0, 32'h3,   32'h0},
        '{4'd2,  OP_R,  4'h4, 2'd0, 32'h0,   32'h3},    // R2 R10 hot add
        '{4'd10, OP_UR, 4'h0, 2'd0, 32'h3,   32'h0},
        '{4'd2,  OP_R,  4'h4, 2'd0, 32'h0,   32'h7},
        '{4'd5,  OP_W,  4'h5, 2'd0, 32'h3,   32'h0},
        '{4'd7,  OP_R,  4'h8, 2'd2, 32'h0,   32'h103},  // R7 ID low
        '{4'd7,  OP_R,  4'h0, 2'd2, 32'h0,   32'hA03},  // R7 ID high
        '{4'd11, OP_R,  4'h8, 2'd0, 32'h0,   32'h03},   // R11 byte read
        '{4'd11, OP_R,  4'h0, 2'd0, 32'h0,   32'h03},
        '{4'd3,  OP_W,  4'h4, 2'd0, 32'h06,  32'h0},    // R3 bit1 wins
        '{4'd3,  OP_R,  4'h4, 2'd0, 32'h0,   32'h5},
        '{4'd3,  OP_W,  4'h4, 2'd0, 32'h04,  32'h0},
        '{4'd3,  OP_R,  4'h4, 2'd0, 32'h0,   32'h1},
        '{4'd4,  OP_W,  4'h4, 2'd0, 32'h10,  32'h0},
        '{4'd2,  OP_R,  4'h4, 2'd0, 32'h0,   32'h11},   // R2 bit4
        '{4'd10, OP_PC, 4'h0, 2'd0, 32'h6,   32'h0},
        '{4'd10, OP_UR, 4'h0, 2'd0, 32'h6,   32'h0},
        '{4'd6,  OP_W,  4'h0, 2'd2, 32'h7,   32'h0},
        '{4'd6,  OP_W,  4'h5, 2'd0, 32'h0,   32'h0},    // R6 wrap to 3
        '{4'd6,  OP_R,  4'h8, 2'd2, 32'h0,   32'h3},
        '{4'd7,  OP_R,  4'h0, 2'd2, 32'h0,   32'h0},
        '{4'd4,  OP_W,  4'h4, 2'd0, 32'h08,  32'h0},    // R4 eject slot3
        '{4'd4,  OP_R,  4'h4, 2'd0, 32'h0,   32'h0},
        '{4'd6,  OP_W,  4'h5, 2'd0, 32'h0,   32'h0},
        '{4'd6,  OP_R,  4'h8, 2'd2, 32'h0,   32'h6},
        '{4'd3,  OP_W,  4'h4, 2'd0, 32'h04,  32'h0},
        '{4'd6,  OP_W,  4'h5, 2'd0, 32'h0,   32'h0},    // R6 miss
        '{4'd6,  OP_R,  4'h8, 2'd2, 32'h0,   32'h6},
        '{4'd4,  OP_W,  4'h0, 2'd2, 32'h0,   32'h0},
        '{4'd4,  OP_W,  4'h4, 2'd0, 32'h08,  32'h0},    // R4 boot eject
        '{4'd4,  OP_R,  4'h4, 2'd0, 32'h0,   32'h1},
        '{4'd4,  OP_W,  4'h4, 2'd0, 32'h10,  32'h0},
        '{4'd4,  OP_R,  4'h4, 2'd0, 32'h0,   32'h1},
        '{4'd4,  OP_W,  4'h0, 2'd2, 32'h4,   32'h0},
        '{4'd4,  OP_W,  4'h4, 2'd0, 32'h10,  32'h0},    // R4 empty slot
        '{4'd4,  OP_R,  4'h4, 2'd0, 32'h0,   32'h0},
        '{4'd9,  OP_W,  4'h0, 2'd2, 32'h9,   32'h0},
        '{4'd9,  OP_R,  4'h4, 2'd0, 32'h0,   32'h0},
        '{4'd9,  OP_R,  4'h8, 2'd2, 32'h0,   32'h0},
        '{4'd9,  OP_W,  4'h5, 2'd0, 32'h3,   32'h0},    // R9 dropped
        '{4'd9,  OP_W,  4'h0, 2'd2, 32'h2,   32'h0},
        '{4'd9,  OP_R,  4'h8, 2'd2, 32'h0,   32'h2},
        '{4'd5,  OP_W,  4'h5, 2'd0, 32'h5,   32'h0},    // R5 ignored
        '{4'd5,  OP_R,  4'h8, 2'd2, 32'h0,   32'h2},
        '{4'd10, OP_PC, 4'h0, 2'd0, 32'h2,   32'h0},
        '{4'd10, OP_R,  4'h4, 2'd0, 32'h0,   32'h1},
        '{4'd10, OP_UD, 4'h0, 2'd0, 32'h2,   32'h0},
        '{4'd10, OP_R,  4'h4, 2'd0, 32'h0,   32'h0},
        '{4'd11, OP_W,  4'h0, 2'd0, 32'h105, 32'h0},    // R11 byte write
        '{4'd11, OP_R,  4'h8, 2'd2, 32'h0,   32'h5},
        '{4'd11, OP_R,  4'h8, 2'd1, 32'h0,   32'h5}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready;
    logic [31:0] req_rdata;
    logic [IDXW-1:0] side_slot = '0;
    logic plug_stb = 1'b0, plug_hot = 1'b0, unplug_req_stb = 1'b0, unplug_done_stb = 1'b0;
    logic irq_pulse, report_pulse, eject_pulse, scan_busy;
    logic [IDXW-1:0] report_slot, eject_slot;
    logic [31:0] report_event, report_code;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cpu_slot_ctrl #(.NSLOTS(N)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .side_slot(side_slot), .plug_stb(plug_stb),
        .plug_hot(plug_hot), .unplug_req_stb(unplug_req_stb),
        .unplug_done_stb(unplug_done_stb), .irq_pulse(irq_pulse),
        .report_pulse(report_pulse), .report_slot(report_slot),
        .report_event(report_event), .report_code(report_code),
        .eject_pulse(eject_pulse), .eject_slot(eject_slot), .scan_busy(scan_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        #1 d = req_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic side(input logic [2:0] op, input logic [IDXW-1:0] slot);
        @(negedge clk);
        side_slot = slot;
        plug_stb = (op == OP_PH || op == OP_PC);
        plug_hot = (op == OP_PH);
        unplug_req_stb = (op == OP_UR);
        unplug_done_stb = (op == OP_UD);
        @(posedge clk); #1;
        plug_stb = 1'b0; plug_hot = 1'b0; unplug_req_stb = 1'b0; unplug_done_stb = 1'b0;
    endtask

    task automatic busy_len(input string req, input int exp);
        int n = 0;
        while (scan_busy) begin
            n++;
            if (req_ready) begin
                errors++;
                $display("FAIL %s: ready high during search, expected 0", req);
            end
            @(posedge clk); #1;
        end
        check(req, 32'(n), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 ready", 32'(req_ready), 32'h1);
        check("R1 busy", 32'(scan_busy), 32'h0);
        check("R1 pulses", {29'h0, irq_pulse, report_pulse, eject_pulse}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_W: reg_write(VEC[i].addr, VEC[i].size, VEC[i].data);
                OP_R: begin
                    reg_read(VEC[i].addr, VEC[i].size, rv);
                    check($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].exp);
                end
                default: side(VEC[i].op, VEC[i].data[IDXW-1:0]);
            endcase
        end

        // R10 interrupt timing
        side(OP_PH, 3'd1);
        check("R10 irq", 32'(irq_pulse), 32'h1);
        @(posedge clk); #1;
        check("R10 irq fall", 32'(irq_pulse), 32'h0);

        // R8 report path
        reg_write(4'h0, 2'd2, 32'h1);
        reg_write(4'h5, 2'd0, 32'h1);
        reg_write(4'h8, 2'd2, 32'h55);
        check("R8 no pulse on event", 32'(report_pulse), 32'h0);
        reg_write(4'h5, 2'd0, 32'h2);
        reg_write(4'h8, 2'd2, 32'h77);
        check("R8 pulse", 32'(report_pulse), 32'h1);
        check("R8 slot", 32'(report_slot), 32'h1);
        check("R8 event", report_event, 32'h55);
        check("R8 code", report_code, 32'h77);
        @(posedge clk); #1;
        check("R8 pulse fall", 32'(report_pulse), 32'h0);

        // R4 eject pulse
        reg_write(4'h4, 2'd0, 32'h08);
        check("R4 eject", 32'(eject_pulse), 32'h1);
        check("R4 eject slot", 32'(eject_slot), 32'h1);
        reg_write(4'h4, 2'd0, 32'h02);
        check("R4 eject fall", 32'(eject_pulse), 32'h0);
        reg_read(4'h4, 2'd0, rv);
        check("R4 flags after eject", rv, 32'h0);

        // R6 miss timing: full lap of N cycles
        reg_write(4'h5, 2'd0, 32'h0);
        busy_len("R6 miss length", N);
        reg_read(4'h8, 2'd2, rv);
        check("R6 miss keeps selector", rv, 32'h1);

        // R6 hit three slots ahead
        side(OP_PH, 3'd4);
        reg_write(4'h5, 2'd0, 32'h0);
        busy_len("R6 hit length", 4);
        reg_read(4'h8, 2'd2, rv);
        check("R6 hit selector", rv, 32'h4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule